// File: doc/BRIEF.md
# Pad Wake Condition Detector

This block watches a set of digital pads while the rest of the chip sleeps and raises a single wake request when any enabled pad meets the condition set up for it. Each pad has three configuration bits. One arms the pad. One chooses between a level trigger and an edge trigger. One inverts the sense, so a single pad can wake on a high level, a low level, a rising edge or a falling edge.

Pad inputs pass through a two-flop synchroniser before detection, and edge detection compares each synchronised sample with the one before it. A detected condition sets a sticky per-pad status bit, and the wake request is the OR of all of these bits. Software sets the block up through a simple register port. It clears status by writing ones to the status word. When a pad's configuration changes, the block reloads that pad's edge history, so an old sample cannot produce a false edge.

Top module: `padwake_detector`

## Requirements
- R1: After reset, the enable, edge, invert and status words all read 0 and `wake_o` is low.
- R2: Word address 0 holds the per-pad enables, address 1 the edge selects and address 2 the invert bits. Bit n of each word belongs to pad n, and each of these words reads back what was last written. Bits at or above NUM_PADS (28 by default) read 0 and writes to them have no effect.
- R3: A pad whose enable bit is 0 never sets its status bit, whatever its edge and invert bits and its input do.
- R4: With edge=0, an enabled pad sets its status bit while its synchronised input is high (invert=0) or low (invert=1).
- R5: With edge=1, an enabled pad sets its status bit only on a 0-to-1 change of its synchronised input (invert=0) or a 1-to-0 change (invert=1). A steady level sets nothing.
- R6: Status bits are sticky. They read at address 3, bit n for pad n, and `wake_o` is high exactly when any status bit is 1.
- R7: Writing address 3 clears every status bit whose data bit is 1, in the cycle of the write, and leaves the others unchanged. A level condition that still holds sets its bit again one cycle later.
- R8: A pad change driven just after a clock edge is seen in status and `wake_o` after the third rising edge, and not after the second.
- R9: A write that changes any configuration bit of a pad reloads that pad's edge history from its current synchronised input. A level change that happened while the pad was disabled is therefore not taken as an edge once edge mode is enabled.
- R10: A read of an address that holds no register returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PADS | Asynchronous pad levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |
| wake_o | output | 1 | Wake request, OR of all status bits |

## Verification
The in-RTL assertions watch every pad on every cycle. They check that a disabled pad's status stays clear, that a clear write always empties the bit it targets, that status never drops without a clear, and that an edge-mode pad never fires while its input is unchanged. Several behaviours can only be shown by the bench's scenarios: the exact three-edge latency, the choice among the four trigger conditions, a level re-setting its bit right after a clear, and reconfiguration hiding a level change made while the pad was disabled.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_ARM    = 3'd0,
      RA_EDGE   = 3'd1,
      RA_INVERT = 3'd2,
      RA_STATUS = 3'd3
   } wake_reg_e;

   typedef struct packed {
      logic arm;
      logic edge_mode;
      logic invert;
   } pin_cfg_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wake_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
   import wake_pkg::*;
#(
   parameter int unsigned NUM_PADS = 28,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [NUM_PADS-1:0]   arm_o,
   output logic [NUM_PADS-1:0]   edge_o,
   output logic [NUM_PADS-1:0]   inv_o,
   output logic [NUM_PADS-1:0]   resync_o,
   output logic [NUM_PADS-1:0]   clr_o
);
   if (NUM_PADS < 1 || NUM_PADS > DATA_W) begin : g_bad_width
      $error("wake_cfg_regs: NUM_PADS must be 1..DATA_W");
   end

   logic [NUM_PADS-1:0] arm_q, edge_q, inv_q;
   logic [NUM_PADS-1:0] wdat;
   logic                hit_arm, hit_edge, hit_inv, hit_stat;
   logic                unused_wdat_ok;

   assign wdat           = wr_data[NUM_PADS-1:0];
   assign unused_wdat_ok = &{1'b1, wr_data};

   assign hit_arm  = wr_en && (wr_addr == RA_ARM);
   assign hit_edge = wr_en && (wr_addr == RA_EDGE);
   assign hit_inv  = wr_en && (wr_addr == RA_INVERT);
   assign hit_stat = wr_en && (wr_addr == RA_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= '0;
         edge_q <= '0;
         inv_q  <= '0;
      end else begin
         if (hit_arm)  arm_q  <= wdat;
         if (hit_edge) edge_q <= wdat;
         if (hit_inv)  inv_q  <= wdat;
      end
   end

   always_comb begin
      resync_o = '0;
      if (hit_arm)  resync_o = wdat ^ arm_q;
      if (hit_edge) resync_o = wdat ^ edge_q;
      if (hit_inv)  resync_o = wdat ^ inv_q;
   end

   assign clr_o  = hit_stat ? wdat : '0;
   assign arm_o  = arm_q;
   assign edge_o = edge_q;
   assign inv_o  = inv_q;

   // R2: a configuration word only moves on a write to its own address
   p_arm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_arm |=> $stable(arm_q));
endmodule

// File: rtl/wake_pin_detect.sv
module wake_pin_detect
   import wake_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sync_i,
   input  pin_cfg_t cfg_i,
   input  logic     resync_i,
   input  logic     clr_i,
   output logic     status_o
);
   logic prev_q, status_q;
   logic level_hit, edge_hit, cond;

   // history follows the input while armed, and is reloaded on any config change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       prev_q <= 1'b0;
      else if (resync_i || cfg_i.arm)   prev_q <= sync_i;
   end

   assign level_hit = cfg_i.invert ? ~sync_i : sync_i;
   assign edge_hit  = cfg_i.invert ? (prev_q & ~sync_i) : (~prev_q & sync_i);
   assign cond      = cfg_i.arm & (cfg_i.edge_mode ? edge_hit : level_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_q <= 1'b0;
      else if (clr_i)  status_q <= 1'b0;
      else if (cond)   status_q <= 1'b1;
   end

   assign status_o = status_q;

   // R3: an unarmed pad cannot raise status
   p_disarmed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.arm && !status_q) |=> !status_q);
   // R7: a clear always empties the bit
   p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !status_q);
   // R6: status is sticky without a clear
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_i) |=> status_q);
   // R5: edge mode needs an actual change of the input
   p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.arm && cfg_i.edge_mode && (sync_i == prev_q) && !status_q && !clr_i)
      |=> !status_q);
endmodule

// File: rtl/padwake_detector.sv
module padwake_detector
   import wake_pkg::*;
#(
   parameter int unsigned NUM_PADS    = 28,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PADS-1:0]   pad_i,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  wake_o
);
   localparam int unsigned PAD_W = NUM_PADS;

   if (NUM_PADS < 1 || NUM_PADS > DATA_W) begin : g_bad_pads
      $error("padwake_detector: NUM_PADS must be 1..DATA_W");
   end

   logic [PAD_W-1:0] pad_sync, arm, edge_sel, inv, resync, clr, status;

   wake_sync #(.WIDTH(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pad_i), .sync_o(pad_sync));

   wake_cfg_regs #(.NUM_PADS(PAD_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .arm_o(arm), .edge_o(edge_sel), .inv_o(inv),
      .resync_o(resync), .clr_o(clr));

   for (genvar p = 0; p < PAD_W; p++) begin : g_pin
      pin_cfg_t cfg;
      assign cfg = '{arm: arm[p], edge_mode: edge_sel[p], invert: inv[p]};
      wake_pin_detect u_det (
         .clk(clk), .rst_n(rst_n), .sync_i(pad_sync[p]), .cfg_i(cfg),
         .resync_i(resync[p]), .clr_i(clr[p]), .status_o(status[p]));
   end

   assign wake_o = |status;

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         RA_ARM:    rd_data[PAD_W-1:0] = arm;
         RA_EDGE:   rd_data[PAD_W-1:0] = edge_sel;
         RA_INVERT: rd_data[PAD_W-1:0] = inv;
         RA_STATUS: rd_data[PAD_W-1:0] = status;
         default:   rd_data = '0;
      endcase
   end

   // R6: once raised, the wake request stays until a status write
   p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && !(wr_en && wr_addr == RA_STATUS)) |=> wake_o);
endmodule

// File: tb/padwake_detector_bench.sv
`timescale 1ns/100ps
module padwake_detector_bench;
   localparam int unsigned NP = 28;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pad_i = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          wake_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #2.5 clk = ~clk;

   padwake_detector u_padwake_detector (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wake_o(wake_o));

   // fields: arm, edge, invert, pad before, pad after, expected status
   localparam logic [5:0] VEC [14] = '{
      6'b100_011, 6'b100_000, 6'b101_101, 6'b101_110,
      6'b110_011, 6'b110_110, 6'b110_100, 6'b111_101,
      6'b111_010, 6'b111_000, 6'b000_010, 6'b011_100,
      6'b100_111, 6'b101_001 };

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [DW-1:0] v;
      idle(3);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(3'(a), v);
         check("R1", v, '0);
      end
      check("R1", {31'b0, wake_o}, 32'd0);
      rst_n = 1'b1;
      idle(2);

      // R2 readback and reserved bits
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v); check("R2", v, 32'h0FFF_FFFF);
      wr(3'd2, 32'hA5A5_A5A5);
      rd(3'd2, v); check("R2", v, 32'h05A5_A5A5);
      rd(3'd0, v); check("R2", v, 32'h0);
      // R10 unmapped address
      rd(3'd5, v); check("R10", v, '0);
      wr(3'd1, 0); wr(3'd2, 0);

      // table walk
      for (int i = 0; i < 14; i++) begin
         automatic int pin = (i * 5 + 2) % NP;
         automatic logic [5:0] t = VEC[i];
         automatic string tag = !t[5] ? "R3" : (t[4] ? "R5" : "R4");
         pad_i = '0;
         pad_i[pin] = t[2];
         idle(4);
         wr(3'd1, 32'(t[4]) << pin);
         wr(3'd2, 32'(t[3]) << pin);
         wr(3'd0, 32'(t[5]) << pin);
         idle(4);
         wr(3'd3, 32'hFFFF_FFFF);
         pad_i[pin] = t[1];
         idle(5);
         rd(3'd3, v);
         check(tag, v, 32'(t[0]) << pin);
         check("R6", {31'b0, wake_o}, {31'b0, t[0]});
         wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0);
         pad_i = '0;
         idle(4);
         wr(3'd3, 32'hFFFF_FFFF);
      end

      // R8 latency: level high on pad 27
      wr(3'd0, 32'h0800_0000);
      idle(3);
      @(negedge clk); pad_i[27] = 1'b1;
      @(negedge clk); @(negedge clk);
      rd(3'd3, v); check("R8", v, 32'h0);
      @(negedge clk);
      rd(3'd3, v); check("R8", v, 32'h0800_0000);
      check("R8", {31'b0, wake_o}, 32'd1);
      // R7 clear with level still present: 0 in clear cycle, back next cycle
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h0800_0000;
      @(negedge clk);
      wr_en = 1'b0;
      rd(3'd3, v); check("R7", v, 32'h0);
      @(negedge clk);
      rd(3'd3, v); check("R7", v, 32'h0800_0000);
      wr(3'd0, 0); pad_i = '0; idle(4); wr(3'd3, 32'hFFFF_FFFF);

      // R7 partial clear: pads 0 and 9 rising
      wr(3'd1, 32'h0000_0201); wr(3'd0, 32'h0000_0201);
      idle(2);
      pad_i[0] = 1'b1; pad_i[9] = 1'b1;
      idle(5);
      rd(3'd3, v); check("R5", v, 32'h0000_0201);
      wr(3'd3, 32'h0000_0001);
      rd(3'd3, v); check("R7", v, 32'h0000_0200);
      check("R6", {31'b0, wake_o}, 32'd1);
      wr(3'd3, 32'h0000_0200);
      rd(3'd3, v); check("R7", v, 32'h0);
      check("R6", {31'b0, wake_o}, 32'd0);
      wr(3'd0, 0); wr(3'd1, 0); pad_i = '0; idle(4); wr(3'd3, 32'hFFFF_FFFF);

      // R9 level change while disabled must not look like an edge
      wr(3'd0, 32'h0000_0010); wr(3'd0, 0);
      pad_i[4] = 1'b1;
      idle(5);
      wr(3'd1, 32'h0000_0010);
      wr(3'd0, 32'h0000_0010);
      idle(6);
      rd(3'd3, v); check("R9", v, 32'h0);
      check("R9", {31'b0, wake_o}, 32'd0);

      // R3 disabled pad with edge and invert set, toggling input
      wr(3'd0, 0); wr(3'd2, 32'h0000_0040); wr(3'd1, 32'h0000_0040);
      wr(3'd3, 32'hFFFF_FFFF);
      for (int k = 0; k < 6; k++) begin
         pad_i[6] = ~pad_i[6];
         idle(3);
      end
      rd(3'd3, v); check("R3", v & 32'h40, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule